// File: doc/BRIEF.md
# Sprite Range Evaluation Unit

This unit decides which sprites appear on the next scanline. It runs once per line, in the background-fetch part of that line. A start strobe begins a pass over a 64-entry sprite table, and the pass reads the entries through a synchronous read port. Each entry holds four bytes: the vertical position, the tile number, an attribute byte and the horizontal position. For each entry the unit checks whether the line number given for the following scanline falls inside the sprite's vertical span. The span is 8 rows or 16 rows, chosen by a size-mode input.

For each in-range sprite the unit writes a compact record into a temporary store of eight slots. A record holds the tile number, the horizontal position, five attribute bits and the row within the sprite that the next line will show. A vertical-flip bit mirrors that row. Records are written in table order until the store is full. Sprites found in range after that are discarded, and a sticky overflow flag is raised. The pattern fetch stage downstream reads the slot contents and the hit count.

The passes are paced so that a full pass of 64 entries takes a fixed number of cycles, which lets it fit inside the line's background-fetch window. The start strobe clears the store and the hit count. The overflow flag is cleared only by a separate strobe, which is issued at the start of the pre-render line.

Top module: `sprite_range_eval`

## Requirements
- R1: After `start`, `busy` is high for exactly 64*PACE cycles. During that time `tbl_addr` presents entries 0, 1, …, 63 in ascending order, each for PACE consecutive cycles. `done` pulses for one cycle in the cycle where `busy` falls. The table port returns `tbl_data` one cycle after `tbl_addr`.
- R2: In 8-row mode (`tall_mode`=0), a sprite is in range when d = (line − Y) mod 256 is less than 8. Here Y is `tbl_data[7:0]`.
- R3: In 16-row mode (`tall_mode`=1), a sprite is in range when d < 16, with d computed the same unsigned way as in R2.
- R4: A stored record holds the tile (`tbl_data[15:8]`) in `slot_tile` and X (`tbl_data[31:24]`) in `slot_x`. `slot_attr` is {attr[7], attr[6], attr[5], attr[1], attr[0]}, where attr is `tbl_data[23:16]`. Slot k occupies bits [8k+7:8k], [5k+4:5k] and [4k+3:4k] of the respective outputs.
- R5: `slot_row` holds d. In 8-row mode it is 3 bits wide with bit 3 at zero. When attr[7] is set, the row is inverted: 7−d in 8-row mode, 15−d in 16-row mode.
- R6: At most 8 in-range sprites are stored, in slots 0..7, in ascending table order. `hit_count` gives their number. Later in-range sprites leave the slots and the count unchanged.
- R7: `overflow` goes to 1 when an in-range sprite is found while 8 are already stored. It stays at 1 until `ovf_clear` is pulsed. If both happen in the same cycle, the set wins.
- R8: `start` clears every slot to zero and clears `hit_count`. It does not change `overflow`.
- R9: After reset, all slots, `hit_count`, `overflow`, `busy` and `done` are zero.
- R10: `next_line` and `tall_mode` are captured on `start`. Changes to them during a pass have no effect on that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass; clears store and count |
| ovf_clear | input | 1 | Clears the overflow flag (pre-render line) |
| next_line | input | 8 | Scanline number the pass targets |
| tall_mode | input | 1 | 0: 8-row sprites, 1: 16-row sprites |
| tbl_addr | output | 6 | Sprite table entry index |
| tbl_data | input | 32 | Entry read one cycle after address: {X, attr, tile, Y} |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at end of pass |
| slot_tile | output | 64 | Tile number per slot |
| slot_x | output | 64 | Horizontal position per slot |
| slot_attr | output | 40 | Five attribute bits per slot |
| slot_row | output | 32 | Fine row per slot |
| hit_count | output | 4 | Number of stored records (0..8) |
| overflow | output | 1 | Sticky drop flag |

## Verification
A faulty range compare or row computation shows up in the stored records at the end of a pass. At that point the bench sees a wrong count, a wrong slot field, or a sprite missing from its table-order position. A store index that goes wrong after the eighth hit overwrites an earlier slot or fails to raise `overflow`. Both are visible in the same cycle `done` pulses. Pacing and sequencing faults change the address sequence or the busy length, and the bench checks these on every cycle of every pass.

// File: rtl/sre_pkg.sv
package sre_pkg;
  typedef struct packed {
    logic [7:0] xpos;
    logic [7:0] attr;
    logic [7:0] tile;
    logic [7:0] ypos;
  } sat_entry_t;

  typedef struct packed {
    logic [7:0] tile;
    logic [7:0] xpos;
    logic [4:0] attr;
    logic [3:0] row;
  } slot_rec_t;

  localparam int SLOT_W = $bits(slot_rec_t);

  function automatic logic [4:0] squeeze_attr(input logic [7:0] a);
    return {a[7], a[6], a[5], a[1], a[0]};
  endfunction
endpackage

// File: rtl/sre_sequencer.sv
module sre_sequencer #(
  parameter int NENT = 64,
  parameter int PACE = 4,
  localparam int AW = $clog2(NENT),
  localparam int PW = (PACE > 1) ? $clog2(PACE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] idx,
  output logic          busy,
  output logic          done,
  output logic          eval_en
);
  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        idx   <= '0;
        phase <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        if (phase == PW'(PACE - 1)) begin
          phase <= '0;
          if (idx == AW'(NENT - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  assign eval_en = busy && (phase == PW'(PACE - 1));

  assert_order_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(start)) |->
      (idx == $past(idx) || idx == $past(idx) + 1'b1));

  assert_done_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/sre_match.sv
module sre_match
  import sre_pkg::*;
(
  input  logic       tall,
  input  logic [7:0] line,
  input  sat_entry_t ent,
  output logic       hit,
  output slot_rec_t  rec
);
  logic [7:0] diff;
  logic [3:0] flip_mask;

  always_comb begin
    diff      = line - ent.ypos;
    hit       = tall ? (diff < 8'd16) : (diff < 8'd8);
    flip_mask = ent.attr[7] ? (tall ? 4'hF : 4'h7) : 4'h0;
    rec.tile  = ent.tile;
    rec.xpos  = ent.xpos;
    rec.attr  = squeeze_attr(ent.attr);
    rec.row   = (tall ? diff[3:0] : {1'b0, diff[2:0]}) ^ flip_mask;
  end
endmodule

// File: rtl/sre_store.sv
module sre_store
  import sre_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int CW = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   wr_en,
  input  slot_rec_t              din,
  input  logic                   ovf_clear,
  output logic [NSLOT*SLOT_W-1:0] flat,
  output logic [CW-1:0]          cnt,
  output logic                   ovf
);
  slot_rec_t slots [NSLOT];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      for (int i = 0; i < NSLOT; i++) slots[i] <= '0;
    end else if (wr_en && cnt < CW'(NSLOT)) begin
      slots[cnt[$clog2(NSLOT)-1:0]] <= din;
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (wr_en && cnt == CW'(NSLOT)) ovf <= 1'b1;
    else if (ovf_clear) ovf <= 1'b0;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_flat
    assign flat[k*SLOT_W +: SLOT_W] = slots[k];
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(NSLOT));
  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(clear)) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> ($past(cnt) == CW'(NSLOT)));
  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf) |-> $past(ovf_clear));
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> (cnt == '0));
endmodule

// File: rtl/sprite_range_eval.sv
module sprite_range_eval
  import sre_pkg::*;
#(
  parameter int NENT  = 64,
  parameter int NSLOT = 8,
  parameter int PACE  = 4,
  localparam int AW = $clog2(NENT),
  localparam int CW = $clog2(NSLOT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               ovf_clear,
  input  logic [7:0]         next_line,
  input  logic               tall_mode,
  output logic [AW-1:0]      tbl_addr,
  input  logic [31:0]        tbl_data,
  output logic               busy,
  output logic               done,
  output logic [NSLOT*8-1:0] slot_tile,
  output logic [NSLOT*8-1:0] slot_x,
  output logic [NSLOT*5-1:0] slot_attr,
  output logic [NSLOT*4-1:0] slot_row,
  output logic [CW-1:0]      hit_count,
  output logic               overflow
);
  logic       eval_en, hit;
  logic [7:0] line_q;
  logic       tall_q;
  slot_rec_t  rec;
  logic [NSLOT*SLOT_W-1:0] flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      tall_q <= 1'b0;
    end else if (start) begin
      line_q <= next_line;
      tall_q <= tall_mode;
    end
  end

  sre_sequencer #(.NENT(NENT), .PACE(PACE)) u_seq (
    .clk(clk), .rst(rst), .start(start), .idx(tbl_addr),
    .busy(busy), .done(done), .eval_en(eval_en));

  sre_match u_match (
    .tall(tall_q), .line(line_q), .ent(sat_entry_t'(tbl_data)),
    .hit(hit), .rec(rec));

  sre_store #(.NSLOT(NSLOT)) u_store (
    .clk(clk), .rst(rst), .clear(start), .wr_en(eval_en && hit),
    .din(rec), .ovf_clear(ovf_clear), .flat(flat),
    .cnt(hit_count), .ovf(overflow));

  for (genvar k = 0; k < NSLOT; k++) begin : g_out
    slot_rec_t s;
    assign s = flat[k*SLOT_W +: SLOT_W];
    assign slot_tile[k*8 +: 8] = s.tile;
    assign slot_x[k*8 +: 8]    = s.xpos;
    assign slot_attr[k*5 +: 5] = s.attr;
    assign slot_row[k*4 +: 4]  = s.row;
  end

  assert_capture_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(start)) |-> ($stable(line_q) && $stable(tall_q)));
endmodule

// File: tb/test_sprite_range_eval.sv
module test_sprite_range_eval;
  localparam int CLK_PERIOD = 10;
  localparam int PACE = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, ovf_clear = 1'b0;
  logic [7:0] next_line = '0;
  logic tall_mode = 1'b0;
  logic [5:0] tbl_addr;
  logic [31:0] tbl_data = '0;
  logic busy, done, overflow;
  logic [63:0] slot_tile, slot_x;
  logic [39:0] slot_attr;
  logic [31:0] slot_row;
  logic [3:0] hit_count;

  logic [31:0] mem [64];
  int checks = 0, fails = 0;
  bit exp_ovf = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tbl_data <= mem[tbl_addr];

  sprite_range_eval #(.PACE(PACE)) i_sprite_range_eval (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_table();
    for (int i = 0; i < 64; i++) mem[i] = {8'h11, 8'h00, 8'h22, 8'hF0};
  endtask

  function automatic logic [31:0] ent(logic [7:0] y, logic [7:0] t, logic [7:0] a, logic [7:0] x);
    return {x, a, t, y};
  endfunction

  // runs one pass; optionally perturbs inputs mid-pass (R10); checks R1, R2..R8
  task automatic run_pass(string req, logic [7:0] line, bit tall, bit perturb);
    logic [7:0] et [8], ex [8];
    logic [4:0] ea [8];
    logic [3:0] er [8];
    int n = 0, cyc = 0;
    bit addr_ok = 1;
    for (int k = 0; k < 8; k++) begin et[k] = 0; ex[k] = 0; ea[k] = 0; er[k] = 0; end
    for (int i = 0; i < 64; i++) begin
      logic [7:0] d, a;
      bit h;
      d = line - mem[i][7:0];
      a = mem[i][23:16];
      h = tall ? (d < 16) : (d < 8);
      if (h) begin
        if (n < 8) begin
          et[n] = mem[i][15:8];
          ex[n] = mem[i][31:24];
          ea[n] = {a[7], a[6], a[5], a[1], a[0]};
          er[n] = tall ? (a[7] ? 4'd15 - d[3:0] : d[3:0])
                       : (a[7] ? 4'd7 - {1'b0, d[2:0]} : {1'b0, d[2:0]});
          n++;
        end else exp_ovf = 1;
      end
    end
    @(negedge clk);
    next_line = line; tall_mode = tall; start = 1;
    @(negedge clk);
    start = 0;
    while (busy && cyc < 2000) begin
      if (tbl_addr != 6'(cyc / PACE)) addr_ok = 0;
      cyc++;
      if (perturb && cyc == 10) begin next_line = line + 8'd40; tall_mode = !tall; end
      @(negedge clk);
    end
    chk("R1", {req, " addr order"}, addr_ok, 1);
    chk("R1", {req, " busy length"}, cyc, 64 * PACE);
    chk("R1", {req, " done pulse"}, done, 1);
    chk("R6", {req, " hit_count"}, hit_count, n);
    chk("R7", {req, " overflow"}, overflow, exp_ovf);
    for (int k = 0; k < 8; k++) begin
      chk("R4", $sformatf("%s slot%0d tile", req, k), slot_tile[k*8 +: 8], et[k]);
      chk("R4", $sformatf("%s slot%0d x", req, k), slot_x[k*8 +: 8], ex[k]);
      chk("R4", $sformatf("%s slot%0d attr", req, k), slot_attr[k*5 +: 5], ea[k]);
      chk("R5", $sformatf("%s slot%0d row", req, k), slot_row[k*4 +: 4], er[k]);
    end
  endtask

  task automatic t_reset();  // R9
    chk("R9", "count", hit_count, 0);
    chk("R9", "overflow", overflow, 0);
    chk("R9", "busy", busy, 0);
    chk("R9", "done", done, 0);
    chk("R9", "slots", {slot_tile, slot_x, slot_attr, slot_row} == '0, 1);
  endtask

  task automatic t_none();  // R2: nothing near the line, wrap case Y above line
    clear_table();
    mem[3] = ent(8'd250, 8'h05, 8'h00, 8'h10);  // d = 8 in 8-row mode: out
    run_pass("R2 none", 8'd2, 0, 0);
    chk("R2", "no hits", hit_count, 0);
  endtask

  task automatic t_small();  // R2 R4 R5
    clear_table();
    mem[5]  = ent(8'd50, 8'hA1, 8'hE3, 8'h33);  // d=0, flipped -> row 7
    mem[20] = ent(8'd43, 8'hA2, 8'h01, 8'h44);  // d=7
    mem[40] = ent(8'd42, 8'hA3, 8'h00, 8'h55);  // d=8 out
    mem[63] = ent(8'd46, 8'hA4, 8'h82, 8'h66);  // d=4 flipped -> 3
    run_pass("R2/R5 small8", 8'd50, 0, 0);
    chk("R2", "three hits", hit_count, 3);
    chk("R5", "flip row slot0", slot_row[3:0], 7);
  endtask

  task automatic t_tall();  // R3 R5
    clear_table();
    mem[0] = ent(8'd100, 8'hB0, 8'h00, 8'h01);  // d=0
    mem[1] = ent(8'd92,  8'hB1, 8'h00, 8'h02);  // d=8
    mem[2] = ent(8'd85,  8'hB2, 8'h80, 8'h03);  // d=15 flipped -> 0
    mem[3] = ent(8'd84,  8'hB3, 8'h00, 8'h04);  // d=16 out
    mem[9] = ent(8'd90,  8'hB4, 8'h80, 8'h05);  // d=10 flipped -> 5
    run_pass("R3 tall", 8'd100, 1, 0);
    chk("R3", "four hits", hit_count, 4);
    chk("R5", "row slot1", slot_row[7:4], 8);
  endtask

  task automatic t_fill();  // R6 R7
    clear_table();
    for (int i = 0; i < 8; i++) mem[i*7] = ent(8'd30, 8'(i), 8'(i), 8'(i*3));
    run_pass("R6 exactly8", 8'd33, 0, 0);
    chk("R7", "no overflow at 8", overflow, 0);
    clear_table();
    for (int i = 0; i < 11; i++) mem[i*5+2] = ent(8'd60 - 8'(i % 8), 8'(8'h40 + i), 8'h00, 8'(i));
    run_pass("R6/R7 eleven", 8'd60, 0, 0);
    chk("R6", "slot7 is 8th in order", slot_tile[63:56], 8'h47);
    chk("R7", "overflow set", overflow, 1);
  endtask

  task automatic t_sticky();  // R7 R8
    clear_table();
    run_pass("R8 restart", 8'd60, 0, 0);
    chk("R8", "overflow kept by start", overflow, 1);
    @(negedge clk); ovf_clear = 1;
    @(negedge clk); ovf_clear = 0;
    exp_ovf = 0;
    chk("R7", "overflow cleared", overflow, 0);
  endtask

  task automatic t_capture();  // R10
    clear_table();
    mem[7]  = ent(8'd20, 8'hC0, 8'h00, 8'h70);  // d=2 at line 22
    mem[30] = ent(8'd52, 8'hC1, 8'h00, 8'h71);  // would hit if perturbed line 62 used
    run_pass("R10 capture", 8'd22, 0, 1);
    chk("R10", "one hit", hit_count, 1);
  endtask

  initial begin
    clear_table();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_none();
    t_small();
    t_tall();
    t_fill();
    t_sticky();
    t_capture();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule